// File: doc/BRIEF.md
# Per-Cycle Spare Element Reconfiguration Controller

This block keeps track of local redundancy for one ring of processing elements. The ring is divided into `NUM_GROUPS` groups. Each group has `GROUP_SIZE` regular elements and one spare of its own. A fault-detection agent outside the block sends fault reports over a valid/ready handshake. Each report names a group and a member inside that group. A broken link is reported as a fault of the element that the link attaches to, so it needs no encoding of its own.

When a group still has its spare, the controller steers the failed member to that spare. The block drives a per-member select map, and the bypass switches of the ring follow this map. A group that has used its spare and then loses another distinct element becomes unrepairable. This state is sticky and appears on a per-group flag and on a ring-level fail output, while the map of that group stays as it was. Every accepted report starts a fixed update window: busy is high for two cycles, then done pulses for one cycle.

Top module: `spareReconfigCtrl`

## Requirements
- R1: A report is taken on a rising edge where `faultValid` and `faultReady` are both high. `faultReady` is high only while the controller is idle, so it is low in both busy cycles and in the done cycle. A report held valid during the done cycle is taken on a later edge.
- R2: The first new fault in a group whose spare is still free sets that member's select bit to 1 and raises `spareUsed` for the group. No other bit changes.
- R3: Groups are independent. A fault reported in one group never changes the select bits or flags of any other group.
- R4: A new fault in a group whose spare is already in use has these effects:
  - it sets that group's `groupUnrepairable` flag and raises `cycleFail`;
  - both stay set until reset;
  - the select map is left unchanged.
- R5: A report that names an element already recorded as failed, or that names an index outside the configured range, changes nothing. It still passes through the busy/done window.
- R6: After an accepted report, `busy` is high for exactly the two following cycles. `done` is high for exactly one cycle right after them, and any change to the map or flags becomes visible in that done cycle.
- R7: A synchronous active-high `rst` clears every fault record and flag, restores the identity map (all select bits 0), and leaves the controller idle with `faultReady` high.
- R8: Within any group, at most one select bit is 1 at any time.
- R9: Select bit index `group*GROUP_SIZE + member` belongs to that logical position. Value 0 selects the element's own physical element, and value 1 selects the group's spare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| faultValid | input | 1 | A fault report is presented |
| faultGroup | input | GROUP_W | Group index of the failed element |
| faultMember | input | MEMBER_W | Member index inside the group |
| faultReady | output | 1 | The controller can take a report this cycle |
| busy | output | 1 | The map update window is in progress |
| done | output | 1 | One-cycle pulse that ends the update window |
| selSpare | output | NUM_GROUPS*GROUP_SIZE | Per-position select: 1 = spare, 0 = own element |
| spareUsed | output | NUM_GROUPS | The group's spare is in use |
| groupUnrepairable | output | NUM_GROUPS | Sticky: the group lost a second element |
| cycleFail | output | 1 | At least one group is unrepairable |

## Verification
Two things can fall in the same cycle: a new report being offered, and the commit and done pulse of the previous report. The bench provokes this by raising `faultValid` for the next report during the done cycle. It then checks that the report was not taken in that cycle: on the next sample `busy` must be low and `faultReady` high. After that, the report must run its own full window, and its map result must match the reference model. Random reports that often repeat elements and hit exhausted groups test ordering further. Each result is compared with a model built from the requirements.

// File: rtl/spare_ctrl_pkg.sv
package spare_ctrl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_UPD1 = 2'd1,
    ST_UPD2 = 2'd2,
    ST_DONE = 2'd3
  } ctrlState_t;

  typedef struct packed {
    logic capture;
    logic commit;
  } ctrlStrobes_t;

endpackage

// File: rtl/spareCtrlFsm.sv
module spareCtrlFsm
  import spare_ctrl_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         faultValid,
  output logic         faultReady,
  output logic         busy,
  output logic         done,
  output ctrlStrobes_t strobes
);

  ctrlState_t state;
  ctrlState_t stateNext;

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: if (faultValid) stateNext = ST_UPD1;
      ST_UPD1: stateNext = ST_UPD2;
      ST_UPD2: stateNext = ST_DONE;
      ST_DONE: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

  assign faultReady      = (state == ST_IDLE);
  assign busy            = (state == ST_UPD1) || (state == ST_UPD2);
  assign done            = (state == ST_DONE);
  assign strobes.capture = faultValid && (state == ST_IDLE);
  assign strobes.commit  = (state == ST_UPD2);

  AST_BUSY_SECOND_CYCLE: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |=> busy); // R6

  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |=> (done && !busy)); // R6

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> (!done && faultReady)); // R6

  AST_TAKE_STARTS_BUSY: assert property (@(posedge clk) disable iff (rst)
    (faultValid && faultReady) |=> busy); // R1

endmodule

// File: rtl/spareGroupSlice.sv
module spareGroupSlice #(
  parameter int GROUP_SIZE = 4,
  parameter int MEMBER_W   = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  commitHit,
  input  logic [MEMBER_W-1:0]   member,
  output logic [GROUP_SIZE-1:0] sel,
  output logic                  spareUsed,
  output logic                  unrepairable
);

  logic [GROUP_SIZE-1:0] failed;
  logic                  alreadyFailed;

  assign alreadyFailed = failed[member];

  always_ff @(posedge clk) begin
    if (rst) begin
      failed       <= '0;
      sel          <= '0;
      spareUsed    <= 1'b0;
      unrepairable <= 1'b0;
    end else if (commitHit && !alreadyFailed) begin
      failed[member] <= 1'b1;
      if (!spareUsed) begin
        sel[member] <= 1'b1;
        spareUsed   <= 1'b1;
      end else begin
        unrepairable <= 1'b1;
      end
    end
  end

  AST_ONE_SPARE_USER: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel)); // R8

  AST_UNREP_STICKY: assert property (@(posedge clk) disable iff (rst)
    unrepairable |=> unrepairable); // R4

  AST_UNREP_MAP_FROZEN: assert property (@(posedge clk) disable iff (rst)
    unrepairable |=> $stable(sel)); // R4

  AST_SPARE_STICKY: assert property (@(posedge clk) disable iff (rst)
    spareUsed |=> spareUsed); // R2

  AST_NO_COMMIT_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
    !commitHit |=> ($stable(sel) && $stable(unrepairable))); // R3

endmodule

// File: rtl/spareMapDatapath.sv
module spareMapDatapath
  import spare_ctrl_pkg::*;
#(
  parameter int NUM_GROUPS = 4,
  parameter int GROUP_SIZE = 4,
  parameter int GROUP_W    = 2,
  parameter int MEMBER_W   = 2
) (
  input  logic                             clk,
  input  logic                             rst,
  input  ctrlStrobes_t                     strobes,
  input  logic [GROUP_W-1:0]               faultGroup,
  input  logic [MEMBER_W-1:0]              faultMember,
  output logic [NUM_GROUPS*GROUP_SIZE-1:0] selSpare,
  output logic [NUM_GROUPS-1:0]            spareUsed,
  output logic [NUM_GROUPS-1:0]            groupUnrepairable,
  output logic                             cycleFail
);

  localparam logic [GROUP_W:0]  GROUP_LIMIT  = (GROUP_W + 1)'(NUM_GROUPS);
  localparam logic [MEMBER_W:0] MEMBER_LIMIT = (MEMBER_W + 1)'(GROUP_SIZE);

  logic [GROUP_W-1:0]  capGroup;
  logic [MEMBER_W-1:0] capMember;
  logic                inRange;

  always_ff @(posedge clk) begin
    if (rst) begin
      capGroup  <= '0;
      capMember <= '0;
    end else if (strobes.capture) begin
      capGroup  <= faultGroup;
      capMember <= faultMember;
    end
  end

  assign inRange = ({1'b0, capGroup} < GROUP_LIMIT) &&
                   ({1'b0, capMember} < MEMBER_LIMIT);

  for (genvar gi = 0; gi < NUM_GROUPS; gi++) begin : gGroup
    logic commitHit;
    assign commitHit = strobes.commit && inRange &&
                       (capGroup == GROUP_W'(gi));

    spareGroupSlice #(
      .GROUP_SIZE(GROUP_SIZE),
      .MEMBER_W  (MEMBER_W)
    ) uSlice (
      .clk         (clk),
      .rst         (rst),
      .commitHit   (commitHit),
      .member      (capMember),
      .sel         (selSpare[gi*GROUP_SIZE +: GROUP_SIZE]),
      .spareUsed   (spareUsed[gi]),
      .unrepairable(groupUnrepairable[gi])
    );
  end

  assign cycleFail = |groupUnrepairable;

  AST_MAP_ONLY_ON_COMMIT: assert property (@(posedge clk) disable iff (rst)
    !strobes.commit |=> $stable(selSpare)); // R6

  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (rst)
    cycleFail |=> cycleFail); // R4

endmodule

// File: rtl/spareReconfigCtrl.sv
module spareReconfigCtrl
  import spare_ctrl_pkg::*;
#(
  parameter int NUM_GROUPS = 4,
  parameter int GROUP_SIZE = 4,
  localparam int GROUP_W  = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
  localparam int MEMBER_W = (GROUP_SIZE > 1) ? $clog2(GROUP_SIZE) : 1
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             faultValid,
  input  logic [GROUP_W-1:0]               faultGroup,
  input  logic [MEMBER_W-1:0]              faultMember,
  output logic                             faultReady,
  output logic                             busy,
  output logic                             done,
  output logic [NUM_GROUPS*GROUP_SIZE-1:0] selSpare,
  output logic [NUM_GROUPS-1:0]            spareUsed,
  output logic [NUM_GROUPS-1:0]            groupUnrepairable,
  output logic                             cycleFail
);

  ctrlStrobes_t strobes;

  spareCtrlFsm uCtrl (
    .clk       (clk),
    .rst       (rst),
    .faultValid(faultValid),
    .faultReady(faultReady),
    .busy      (busy),
    .done      (done),
    .strobes   (strobes)
  );

  spareMapDatapath #(
    .NUM_GROUPS(NUM_GROUPS),
    .GROUP_SIZE(GROUP_SIZE),
    .GROUP_W   (GROUP_W),
    .MEMBER_W  (MEMBER_W)
  ) uPath (
    .clk              (clk),
    .rst              (rst),
    .strobes          (strobes),
    .faultGroup       (faultGroup),
    .faultMember      (faultMember),
    .selSpare         (selSpare),
    .spareUsed        (spareUsed),
    .groupUnrepairable(groupUnrepairable),
    .cycleFail        (cycleFail)
  );

endmodule

// File: tb/sim_spareReconfigCtrl.sv
`timescale 1ns/1ps
module sim_spareReconfigCtrl;

  localparam int NG    = 4;
  localparam int GS    = 4;
  localparam int TOTAL = NG * GS;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             faultValid = 1'b0;
  logic [1:0]       faultGroup = '0;
  logic [1:0]       faultMember = '0;
  logic             faultReady, busy, done, cycleFail;
  logic [TOTAL-1:0] selSpare;
  logic [NG-1:0]    spareUsed, groupUnrepairable;

  logic [TOTAL-1:0] expSel;
  logic [TOTAL-1:0] expFailed;
  logic [NG-1:0]    expUsed, expUnrep;

  int  checks = 0;
  int  errors = 0;
  bit  finished = 0;

  always #2 clk = ~clk;

  spareReconfigCtrl #(.NUM_GROUPS(NG), .GROUP_SIZE(GS)) u0 (
    .clk(clk), .rst(rst), .faultValid(faultValid), .faultGroup(faultGroup),
    .faultMember(faultMember), .faultReady(faultReady), .busy(busy), .done(done),
    .selSpare(selSpare), .spareUsed(spareUsed),
    .groupUnrepairable(groupUnrepairable), .cycleFail(cycleFail)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic modelClear();
    expSel = '0; expFailed = '0; expUsed = '0; expUnrep = '0;
  endtask

  task automatic modelApply(input int g, input int m);
    int idx = g * GS + m;
    if (expFailed[idx]) return;
    expFailed[idx] = 1'b1;
    if (!expUsed[g]) begin
      expSel[idx] = 1'b1;
      expUsed[g]  = 1'b1;
    end else begin
      expUnrep[g] = 1'b1;
    end
  endtask

  task automatic checkState(input string tag);
    check(selSpare == expSel, tag, "selSpare", 64'(selSpare), 64'(expSel));
    check(spareUsed == expUsed, tag, "spareUsed", 64'(spareUsed), 64'(expUsed));
    check(groupUnrepairable == expUnrep, tag, "groupUnrepairable",
          64'(groupUnrepairable), 64'(expUnrep));
    check(cycleFail == (|expUnrep), tag, "cycleFail", 64'(cycleFail), 64'(|expUnrep));
  endtask

  // Called at a falling edge. Optionally presents the next report in the done cycle.
  task automatic sendReport(input int g, input int m, input string tag,
                            input bit preload, input int ng, input int nm);
    faultGroup  = 2'(g);
    faultMember = 2'(m);
    faultValid  = 1'b1;
    while (!faultReady) @(negedge clk);
    @(negedge clk);
    faultValid = 1'b0;
    check(busy && !faultReady && !done, "R1", "first busy cycle", {busy, faultReady, done}, 3'b100);
    @(negedge clk);
    check(busy && !done, "R6", "second busy cycle", {busy, done}, 2'b10);
    modelApply(g, m);
    @(negedge clk);
    check(!busy && done && !faultReady, "R6", "done cycle", {busy, done, faultReady}, 3'b010);
    checkState(tag);
    if (preload) begin
      faultGroup  = 2'(ng);
      faultMember = 2'(nm);
      faultValid  = 1'b1;
    end
    @(negedge clk);
    check(!done && !busy && faultReady, "R1", "idle after done (report in done cycle not taken)",
          {done, busy, faultReady}, 3'b001);
  endtask

  task automatic doReset();
    rst = 1'b1;
    faultValid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    modelClear();
    @(negedge clk);
    check(faultReady && !busy && !done, "R7", "idle after reset", {faultReady, busy, done}, 3'b100);
    checkState("R7");
  endtask

  initial begin
    void'($urandom(32'h5A17));
    modelClear();
    @(negedge clk);
    doReset();

    // R2 / R9: first fault in group 0, member 2 maps bit 2 to the spare
    sendReport(0, 2, "R2", 0, 0, 0);
    check(selSpare[2] == 1'b1, "R9", "bit index 2", 64'(selSpare[2]), 1);
    // R5: repeat of an already failed element is ignored
    sendReport(0, 2, "R5", 0, 0, 0);
    // R4: second distinct fault in group 0
    sendReport(0, 1, "R4", 0, 0, 0);
    check(selSpare[1] == 1'b0, "R4", "map unchanged for second fault", 64'(selSpare[1]), 0);
    // R4: third fault, flag still sticky, map still frozen
    sendReport(0, 3, "R4", 0, 0, 0);
    // R3 / R9: top boundary position, other groups untouched; preload next report in done cycle (R1)
    sendReport(3, 3, "R3", 1, 2, 0);
    check(selSpare[15] == 1'b1, "R9", "bit index 15", 64'(selSpare[15]), 1);
    sendReport(2, 0, "R1", 0, 0, 0);
    check(selSpare[8] == 1'b1, "R9", "bit index 8", 64'(selSpare[8]), 1);
    check(groupUnrepairable[2] == 1'b0, "R3", "group 2 independent of group 0", 64'(groupUnrepairable[2]), 0);

    // R7: reset in the middle of operation clears everything
    doReset();

    // Random reports: repeats and exhausted groups occur often
    for (int i = 0; i < 60; i++) begin
      int g  = int'($urandom_range(NG - 1));
      int m  = int'($urandom_range(GS - 1));
      int g2 = int'($urandom_range(NG - 1));
      int m2 = int'($urandom_range(GS - 1));
      bit pl = ($urandom_range(3) == 0);
      sendReport(g, m, "R8", pl, g2, m2);
      for (int k = 0; k < NG; k++) begin
        check($countones(selSpare[k*GS +: GS]) <= 1, "R8", "one select per group",
              64'(selSpare[k*GS +: GS]), 0);
      end
      if (i == 30) doReset();
    end

    if (!finished) begin
      finished = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule